// File: doc/BRIEF.md
# Memory Sleep Entry and Exit Controller

This block sits in front of a synchronous memory array and decides when the array may rest in a low-power sleep state. A sleep request arrives with no timing relation to the clock. It passes through a flop chain to make it safe, and the controller then steps through four phases: awake, entering, asleep and recovering. Entry and exit each take a fixed number of clocks, two by default, counted from the edge at which the synchronised request changes. A single flag output reports that the array is asleep. Array contents are held throughout and are not touched by this block.

Outside the awake phase, the address strobes passed on to the memory controller are forced inactive, so no new access can start. Any access still pending when entry begins is treated as invalid. A one-clock violation pulse reports each clock in which a chip select or an address strobe was seen active while the controller was entering, asleep or recovering. The recovery window after the request is removed is one of the places where such activity is illegal.

Top module: `mem_doze_ctrl`

## Requirements
- R1: While `rst_n` is low the controller is awake: `doze_flag` is 0, `proto_err` is 0 and `stb_pass` equals `stb_act`.
- R2: When `doze_req_async` rises and stays high, `doze_flag` first reads 1 after the (SYNC_STAGES + 1 + ENTRY_CYC)-th rising clock edge, which is the fifth edge with default parameters. It is 0 before that edge.
- R3: When `doze_req_async` falls while asleep, `doze_flag` reads 0 after the (SYNC_STAGES + 1)-th edge. Strobes stay blocked until the (SYNC_STAGES + 1 + EXIT_CYC)-th edge, which is the fifth edge with default parameters.
- R4: In the awake phase `stb_pass` follows `stb_act` bit for bit in the same cycle.
- R5: In the entering, asleep and recovering phases `stb_pass` is all zero, whatever the value of `stb_act`.
- R6: `proto_err` is 1 for exactly the one clock after each clock in which the controller was not awake and any bit of `cs_act` or `stb_act` was 1. Otherwise it is 0. Select or strobe activity in the awake phase never raises it.
- R7: If the synchronised request drops during entry, the controller goes straight to recovery and `doze_flag` never rises. A one-clock request pulse blocks strobes from edge 3 and reopens them at edge 6.
- R8: If the synchronised request rises again during recovery, the controller goes back to entering without reopening the strobes. After a one-clock low gap in the request, `doze_flag` is set again after edge 6, counted from the edge after the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| doze_req_async | input | 1 | Sleep request, asynchronous to `clk` |
| cs_act | input | N_SEL | Chip-select activity, 1 = select asserted |
| stb_act | input | N_STB | Address-strobe activity, 1 = strobe asserted |
| doze_flag | output | 1 | 1 while the array is asleep |
| stb_pass | output | N_STB | Strobes passed to the memory controller, zero unless awake |
| proto_err | output | 1 | One-clock pulse after a clock with illegal select or strobe activity |

## Verification
On every cycle the assertions check the following: the gating of the strobes against the current phase, the one-clock-late relation between illegal activity and the violation pulse, the phase that must come after a request drop during entry or a request rise during recovery, and the phase in which the sleep flag may rise or fall. The exact latencies counted from the asynchronous request edge involve the synchroniser and the entry and exit counters. Only the bench's scenarios show them, by counting edges from the request change to the flag or to the reopened strobes, in both the directed cases and the random sequences.

// File: rtl/doze_pkg.sv
package doze_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE   = 2'd0,
    PH_ENTER   = 2'd1,
    PH_ASLEEP  = 2'd2,
    PH_RECOVER = 2'd3
  } doze_phase_e;

  // Phase step: req is the synchronised request, done means the phase counter is spent.
  function automatic doze_phase_e f_step(input doze_phase_e ph, input logic req, input logic done);
    doze_phase_e nx;
    nx = ph;
    case (ph)
      PH_AWAKE:   if (req) nx = PH_ENTER;
      PH_ENTER:   if (!req) nx = PH_RECOVER; else if (done) nx = PH_ASLEEP;
      PH_ASLEEP:  if (!req) nx = PH_RECOVER;
      PH_RECOVER: if (req) nx = PH_ENTER; else if (done) nx = PH_AWAKE;
      default:    nx = PH_AWAKE;
    endcase
    return nx;
  endfunction

  // Access starts are legal only in the awake phase.
  function automatic logic f_closed(input doze_phase_e ph);
    return ph != PH_AWAKE;
  endfunction

endpackage

// File: rtl/doze_sync.sv
module doze_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/doze_fsm.sv
module doze_fsm
  import doze_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_sync,
  output doze_phase_e phase,
  output logic        cnt_zero
);
  localparam int MAX_CYC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LD = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);

  logic [CNT_W-1:0] cnt;
  doze_phase_e      nxt;
  logic             phase_change;

  assign cnt_zero     = (cnt == '0);
  assign nxt          = f_step(phase, req_sync, cnt_zero);
  assign phase_change = (nxt != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_AWAKE;
      cnt   <= '0;
    end else begin
      phase <= nxt;
      if (phase_change) begin
        if (nxt == PH_ENTER)        cnt <= ENTRY_LD;
        else if (nxt == PH_RECOVER) cnt <= EXIT_LD;
        else                        cnt <= '0;
      end else if (!cnt_zero) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/doze_guard.sv
module doze_guard
  import doze_pkg::*;
#(
  parameter int N_SEL = 3,
  parameter int N_STB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  doze_phase_e      phase,
  input  logic [N_SEL-1:0] cs_act,
  input  logic [N_STB-1:0] stb_act,
  output logic [N_STB-1:0] stb_pass,
  output logic             proto_err
);
  logic closed;
  logic act_seen;

  assign closed   = f_closed(phase);
  assign act_seen = (|cs_act) | (|stb_act);

  generate
    for (genvar i = 0; i < N_STB; i++) begin : g_gate
      assign stb_pass[i] = stb_act[i] & ~closed;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= closed & act_seen;
  end
endmodule

// File: rtl/mem_doze_ctrl.sv
module mem_doze_ctrl
  import doze_pkg::*;
#(
  parameter int N_SEL       = 3,
  parameter int N_STB       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             doze_req_async,
  input  logic [N_SEL-1:0] cs_act,
  input  logic [N_STB-1:0] stb_act,
  output logic             doze_flag,
  output logic [N_STB-1:0] stb_pass,
  output logic             proto_err
);
  logic        req_sync;
  logic        cnt_zero;
  doze_phase_e phase;

  doze_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(doze_req_async), .dout(req_sync)
  );

  doze_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .phase(phase), .cnt_zero(cnt_zero)
  );

  doze_guard #(.N_SEL(N_SEL), .N_STB(N_STB)) u_guard (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cs_act(cs_act), .stb_act(stb_act),
    .stb_pass(stb_pass), .proto_err(proto_err)
  );

  assign doze_flag = (phase == PH_ASLEEP);
endmodule

// File: rtl/doze_chk.sv
module doze_chk
  import doze_pkg::*;
#(
  parameter int N_SEL = 3,
  parameter int N_STB = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_sync,
  input doze_phase_e      phase,
  input logic [N_SEL-1:0] cs_act,
  input logic [N_STB-1:0] stb_act,
  input logic [N_STB-1:0] stb_pass,
  input logic             doze_flag,
  input logic             proto_err
);
  // R4: strobes flow unchanged while awake
  assert_pass_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AWAKE) |-> (stb_pass == stb_act));

  // R5: no strobe reaches the controller outside the awake phase
  assert_block_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_AWAKE) |-> (stb_pass == '0));

  // R6: a violation pulse always has a cause one clock earlier
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(phase != PH_AWAKE && ((|cs_act) || (|stb_act))));

  // R6: activity outside the awake phase is always reported on the next clock
  assert_err_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_AWAKE && ((|cs_act) || (|stb_act))) |=> proto_err);

  // R2: the sleep flag only rises out of the entering phase
  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doze_flag) |-> ($past(phase) == PH_ENTER));

  // R3: the sleep flag only falls into the recovering phase
  assert_flag_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doze_flag) |-> (phase == PH_RECOVER));

  // R7: a request drop during entry leads to recovery
  assert_abort_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ENTER && !req_sync) |=> (phase == PH_RECOVER));

  // R8: a request rise during recovery leads back to entry
  assert_reenter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOVER && req_sync) |=> (phase == PH_ENTER));
endmodule

bind mem_doze_ctrl doze_chk #(.N_SEL(N_SEL), .N_STB(N_STB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .phase(phase),
  .cs_act(cs_act), .stb_act(stb_act), .stb_pass(stb_pass),
  .doze_flag(doze_flag), .proto_err(proto_err)
);

// File: tb/mem_doze_ctrl_tb.sv
module mem_doze_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_SEL = 3;
  localparam int N_STB = 2;
  localparam int SYNC  = 2;
  localparam int ENTRY = 2;
  localparam int EXIT  = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req;
  logic [N_SEL-1:0] cs;
  logic [N_STB-1:0] stb;
  logic             doze_flag;
  logic [N_STB-1:0] stb_pass;
  logic             proto_err;

  int total = 0;
  int bad   = 0;
  bit chk_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_doze_ctrl #(.N_SEL(N_SEL), .N_STB(N_STB), .SYNC_STAGES(SYNC),
                  .ENTRY_CYC(ENTRY), .EXIT_CYC(EXIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .doze_req_async(req), .cs_act(cs), .stb_act(stb),
    .doze_flag(doze_flag), .stb_pass(stb_pass), .proto_err(proto_err)
  );

  // Bench model: 0 awake, 1 entering, 2 asleep, 3 recovering; 'spent' counts clocks in phase.
  logic [SYNC-1:0] hist;
  int  m_ph;
  int  m_spent;
  bit  m_err;

  function automatic bit exp_flag(input int ph);
    return ph == 2;
  endfunction

  function automatic logic [N_STB-1:0] exp_pass(input int ph, input logic [N_STB-1:0] s);
    return (ph == 0) ? s : '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '0; m_ph = 0; m_spent = 0; m_err = 0;
    end else begin
      bit seen;
      seen  = hist[SYNC-1];
      m_err = (m_ph != 0) && ((cs != 0) || (stb != 0));
      case (m_ph)
        0: if (seen) begin m_ph = 1; m_spent = 1; end
        1: if (!seen) begin m_ph = 3; m_spent = 1; end
           else if (m_spent == ENTRY) m_ph = 2;
           else m_spent++;
        2: if (!seen) begin m_ph = 3; m_spent = 1; end
        default: if (seen) begin m_ph = 1; m_spent = 1; end
                 else if (m_spent == EXIT) m_ph = 0;
                 else m_spent++;
      endcase
      hist = {hist[SYNC-2:0], req};
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      check(doze_flag == exp_flag(m_ph), "R2/R3 doze_flag vs model", doze_flag, exp_flag(m_ph));
      if (m_ph == 0) check(stb_pass == exp_pass(m_ph, stb), "R4 pass while awake", stb_pass, exp_pass(m_ph, stb));
      else           check(stb_pass == '0, "R5 blocked outside awake", stb_pass, 0);
      check(proto_err == m_err, "R6 violation pulse", proto_err, m_err);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int n, first_blk, reopen, r;
    bit saw_low, ever_flag, reopened;
    r = $urandom(32'h5EED);
    req = 0; cs = '1; stb = '1; rst_n = 0;
    #1;
    // R1: reset values with selects and strobes driven
    @(negedge clk);
    check(doze_flag == 0, "R1 flag in reset", doze_flag, 0);
    check(proto_err == 0, "R1 err in reset", proto_err, 0);
    check(stb_pass == stb, "R1 pass in reset", stb_pass, stb);
    cs = '0; stb = '0;
    do_reset();
    chk_on = 1;

    // R2: entry latency
    @(negedge clk); req = 1; n = 0;
    do begin @(negedge clk); n++; end while (!doze_flag && n < 30);
    check(n == SYNC + 1 + ENTRY, "R2 entry latency", n, SYNC + 1 + ENTRY);
    repeat (4) @(negedge clk);

    // R3: exit latency with a strobe held (also exercises R6)
    req = 0; stb = 2'b01; n = 0;
    do begin @(negedge clk); n++; end while (doze_flag && n < 30);
    check(n == SYNC + 1, "R3 flag clear latency", n, SYNC + 1);
    do begin @(negedge clk); n++; end while (stb_pass != stb && n < 30);
    check(n == SYNC + 1 + EXIT, "R3 strobe reopen latency", n, SYNC + 1 + EXIT);
    stb = '0;
    repeat (4) @(negedge clk);

    // R7: one-clock request pulse aborts entry
    stb = 2'b01; req = 1; first_blk = 0; reopen = 0; ever_flag = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) req = 0;
      if (doze_flag) ever_flag = 1;
      if (first_blk == 0 && stb_pass == '0) first_blk = k;
      if (first_blk != 0 && reopen == 0 && stb_pass == stb) reopen = k;
    end
    check(!ever_flag, "R7 flag stays low", ever_flag, 0);
    check(first_blk == SYNC + 1, "R7 block edge", first_blk, SYNC + 1);
    check(reopen == SYNC + 2 + EXIT, "R7 reopen edge", reopen, SYNC + 2 + EXIT);
    stb = '0;

    // R8: re-request during recovery
    req = 1; repeat (8) @(negedge clk);
    check(doze_flag == 1, "R8 asleep before gap", doze_flag, 1);
    stb = 2'b10; req = 0; saw_low = 0; reopened = 0; n = 0;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (k == 1) req = 1;
      if (stb_pass != '0) reopened = 1;
      if (!doze_flag) saw_low = 1;
      else if (saw_low && n == 0) n = k;
    end
    check(n == SYNC + 2 + ENTRY, "R8 re-entry edge", n, SYNC + 2 + ENTRY);
    check(!reopened, "R8 strobes stay blocked", reopened, 0);
    stb = '0; req = 0;
    repeat (8) @(negedge clk);

    // Random mix checked every cycle against the model (R2..R8)
    begin
      int hold;
      hold = 0;
      for (int c = 0; c < 4000; c++) begin
        @(negedge clk);
        if (hold == 0) begin
          if ($urandom % 3 != 0) req = ~req;
          hold = ($urandom % 4 == 0) ? 1 : 1 + int'($urandom % 12);
        end else hold--;
        if (m_ph == 0) begin
          cs  = N_SEL'($urandom);
          stb = N_STB'($urandom);
        end else if ($urandom % 8 == 0) begin
          cs  = N_SEL'($urandom);
          stb = N_STB'($urandom);
        end else begin
          cs = '0; stb = '0;
        end
      end
    end
    @(negedge clk);
    chk_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule